// File: doc/BRIEF.md
# Digital frequency-locked loop trim controller

This block pulls a free-running RC oscillator onto a wanted frequency by driving its 11-bit trim word. The trim word has three fields. A range bit picks the low band (100 kHz to 1 MHz) or the high band (1 MHz to 10 MHz). Four coarse bits pick one of sixteen steps inside that band. Six fine bits make small corrections around the chosen step.

A run pulse starts a loop for the frequency on `target_hz_i`. The block derives the range and coarse fields from the target and puts the fine field at mid-span. It then computes a count window of plus or minus 2% around the count a correct oscillator would give over the reference gate. It then asks an external gated counter for a measurement. When the count comes back, the block either declares lock, or moves the fine field one step and asks again.

A loop that cannot converge stops with an error flag after a bounded number of measurements.

Top module: `dfll_trim_ctrl`

## Requirements
- R1: After reset, `trim_o` is 11'h020 (bit 10 range = 0, bits 9:6 coarse = 0, bits 5:0 fine = 32), and `locked_o`, `error_o` and `meas_req_o` are 0.
- R2: A run that is accepted loads the trim word in the next cycle, and clears both flags:
  - the range bit is 1 when the target is at least 1,000,000 Hz;
  - the coarse field is the band offset (target minus base) divided by the band step, truncated and clamped to 0..15; the low band uses base 100,000 and step 56,250, the high band uses base 1,000,000 and step 562,500, and a target below the base gives 0;
  - the fine field is set to 32.
- R3: The expected count is ((Nb+1)·target) >> 15, with Nb = 20 for targets below 650,000 Hz and Nb = 1 otherwise. The window runs from expected·98/100 to expected·102/100, both bounds truncated and both inclusive. It is computed once per run.
- R4: Each measurement is requested by a one-cycle `meas_req_o` pulse. The trim word stays constant until `meas_done_i` returns the count, and the next request follows only after the count has been evaluated.
- R5: A count above the window lowers the fine field by one. A count below the window raises it by one. The fine field saturates at 0 and at 63.
- R6: A count inside the window sets `locked_o`, leaves the trim word unchanged and ends the loop, with no further requests.
- R7: If the 64th measurement of a run is still outside the window, `error_o` is set, the loop ends and that last count does not move the trim word.
- R8: A run pulse while a loop is in progress is ignored: that loop's outcome is unaffected.
- R9: `locked_o` and `error_o` are never both high, and each holds its value until the next accepted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start pulse; accepted only when no loop is active |
| target_hz_i | input | 24 | Wanted oscillator frequency in Hz |
| meas_req_o | output | 1 | One-cycle request for a gated count |
| meas_done_i | input | 1 | Count on `meas_count_i` is valid this cycle |
| meas_count_i | input | 16 | Oscillator cycles counted over the gate |
| trim_o | output | 11 | Oscillator trim word {range, coarse, fine} |
| locked_o | output | 1 | Count landed inside the window |
| error_o | output | 1 | Measurement limit reached without lock |

## Verification
The hardest cases to reach from the ports are the ones that fail to converge. These are fine saturation at either end, and the error exit on the 64th measurement. A real oscillator only reaches them when its process error is larger than the fine span can absorb. The bench's oscillator model adds a frequency offset to the nominal trim-to-frequency curve. Directed runs push that offset far past the fine range in both directions, which drives the fine field into each rail and then runs out the measurement limit. A further directed run sends a second run pulse in the middle of a loop, to show that the request is dropped.

// File: rtl/dfll_pkg.sv
package dfll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } dfll_state_e;

endpackage

// File: rtl/dfll_band_coarse.sv
module dfll_band_coarse #(
    parameter int FREQ_W   = 24,
    parameter int COARSE_W = 4,
    parameter int BASE_HZ  = 100_000,
    parameter int STEP_HZ  = 56_250
) (
    input  logic [FREQ_W-1:0]   target_hz_i,
    output logic [COARSE_W-1:0] coarse_o
);
    localparam int CMAX = (1 << COARSE_W) - 1;

    logic [FREQ_W-1:0] quot;

    always_comb begin
        quot = '0;
        if (target_hz_i >= FREQ_W'(BASE_HZ)) begin
            quot = (target_hz_i - FREQ_W'(BASE_HZ)) / FREQ_W'(STEP_HZ);
        end
        if (quot > FREQ_W'(CMAX)) begin
            coarse_o = COARSE_W'(CMAX);
        end else begin
            coarse_o = quot[COARSE_W-1:0];
        end
    end
endmodule

// File: rtl/dfll_init_calc.sv
module dfll_init_calc #(
    parameter int FREQ_W         = 24,
    parameter int CNT_W          = 16,
    parameter int COARSE_W       = 4,
    parameter int RANGE_SPLIT_HZ = 1_000_000,
    parameter int NB_SPLIT_HZ    = 650_000,
    parameter int LO_BASE_HZ     = 100_000,
    parameter int LO_STEP_HZ     = 56_250,
    parameter int HI_BASE_HZ     = 1_000_000,
    parameter int HI_STEP_HZ     = 562_500,
    parameter int NB_SLOW        = 20,
    parameter int NB_FAST        = 1,
    parameter int REF_SHIFT      = 15,
    parameter int TOL_PCT        = 2
) (
    input  logic [FREQ_W-1:0]   target_hz_i,
    output logic                range_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [CNT_W-1:0]    win_lo_o,
    output logic [CNT_W-1:0]    win_hi_o
);
    localparam int PROD_W = FREQ_W + 16;

    logic [COARSE_W-1:0] band_coarse [2];

    for (genvar g = 0; g < 2; g++) begin : g_band
        localparam int BASE = (g == 0) ? LO_BASE_HZ : HI_BASE_HZ;
        localparam int STEP = (g == 0) ? LO_STEP_HZ : HI_STEP_HZ;
        dfll_band_coarse #(
            .FREQ_W  (FREQ_W),
            .COARSE_W(COARSE_W),
            .BASE_HZ (BASE),
            .STEP_HZ (STEP)
        ) u_band (
            .target_hz_i(target_hz_i),
            .coarse_o   (band_coarse[g])
        );
    end

    logic [PROD_W-1:0] gate_mult, expect_cnt, lo_w, hi_w;

    always_comb begin
        range_o    = (target_hz_i >= FREQ_W'(RANGE_SPLIT_HZ));
        coarse_o   = range_o ? band_coarse[1] : band_coarse[0];
        gate_mult  = (target_hz_i < FREQ_W'(NB_SPLIT_HZ)) ? PROD_W'(NB_SLOW + 1)
                                                         : PROD_W'(NB_FAST + 1);
        expect_cnt = (gate_mult * PROD_W'(target_hz_i)) >> REF_SHIFT;
        lo_w       = (expect_cnt * PROD_W'(100 - TOL_PCT)) / PROD_W'(100);
        hi_w       = (expect_cnt * PROD_W'(100 + TOL_PCT)) / PROD_W'(100);
        win_lo_o   = lo_w[CNT_W-1:0];
        win_hi_o   = hi_w[CNT_W-1:0];
    end
endmodule

// File: rtl/dfll_fine_step.sv
module dfll_fine_step #(
    parameter int CNT_W  = 16,
    parameter int FINE_W = 6
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  win_lo_i,
    input  logic [CNT_W-1:0]  win_hi_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [FINE_W-1:0] fine_o,
    output logic              inside_o
);
    logic too_fast, too_slow;

    always_comb begin
        too_fast = (count_i > win_hi_i);
        too_slow = (count_i < win_lo_i);
        inside_o = !too_fast && !too_slow;
        fine_o   = fine_i;
        if (too_fast && (fine_i != '0)) begin
            fine_o = fine_i - FINE_W'(1);
        end else if (too_slow && (fine_i != '1)) begin
            fine_o = fine_i + FINE_W'(1);
        end
    end
endmodule

// File: rtl/dfll_trim_ctrl.sv
module dfll_trim_ctrl
    import dfll_pkg::*;
#(
    parameter int FREQ_W   = 24,
    parameter int CNT_W    = 16,
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 6,
    parameter int MAX_ITER = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run_i,
    input  logic [FREQ_W-1:0]              target_hz_i,
    output logic                           meas_req_o,
    input  logic                           meas_done_i,
    input  logic [CNT_W-1:0]               meas_count_i,
    output logic [COARSE_W+FINE_W:0]       trim_o,
    output logic                           locked_o,
    output logic                           error_o
);
    localparam int TRIM_W = 1 + COARSE_W + FINE_W;
    localparam int ITER_W = $clog2(MAX_ITER + 1);
    localparam logic [FINE_W-1:0] FINE_MID = FINE_W'(1 << (FINE_W - 1));

    typedef struct packed {
        dfll_state_e       state;
        logic [TRIM_W-1:0] trim;
        logic [CNT_W-1:0]  win_lo;
        logic [CNT_W-1:0]  win_hi;
        logic [ITER_W-1:0] iter;
        logic              locked;
        logic              error;
    } ctrl_t;

    ctrl_t q, d;

    logic                range_bit;
    logic [COARSE_W-1:0] coarse_val;
    logic [CNT_W-1:0]    new_lo, new_hi;
    logic [FINE_W-1:0]   fine_next;
    logic                in_window;
    logic                can_start;

    dfll_init_calc #(
        .FREQ_W  (FREQ_W),
        .CNT_W   (CNT_W),
        .COARSE_W(COARSE_W)
    ) u_init (
        .target_hz_i(target_hz_i),
        .range_o    (range_bit),
        .coarse_o   (coarse_val),
        .win_lo_o   (new_lo),
        .win_hi_o   (new_hi)
    );

    dfll_fine_step #(
        .CNT_W (CNT_W),
        .FINE_W(FINE_W)
    ) u_step (
        .count_i (meas_count_i),
        .win_lo_i(q.win_lo),
        .win_hi_i(q.win_hi),
        .fine_i  (q.trim[FINE_W-1:0]),
        .fine_o  (fine_next),
        .inside_o(in_window)
    );

    always_comb begin
        d         = q;
        can_start = run_i && ((q.state == ST_IDLE) || (q.state == ST_DONE));
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (can_start) begin
                    d.trim   = {range_bit, coarse_val, FINE_MID};
                    d.win_lo = new_lo;
                    d.win_hi = new_hi;
                    d.iter   = '0;
                    d.locked = 1'b0;
                    d.error  = 1'b0;
                    d.state  = ST_REQ;
                end
            end
            ST_REQ: d.state = ST_WAIT;
            ST_WAIT: begin
                if (meas_done_i) begin
                    d.iter = q.iter + ITER_W'(1);
                    if (in_window) begin
                        d.locked = 1'b1;
                        d.state  = ST_DONE;
                    end else if (q.iter == ITER_W'(MAX_ITER - 1)) begin
                        d.error = 1'b1;
                        d.state = ST_DONE;
                    end else begin
                        d.trim[FINE_W-1:0] = fine_next;
                        d.state            = ST_REQ;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.trim   <= {1'b0, {COARSE_W{1'b0}}, FINE_MID};
            q.win_lo <= '0;
            q.win_hi <= '0;
            q.iter   <= '0;
            q.locked <= 1'b0;
            q.error  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign meas_req_o = (q.state == ST_REQ);
    assign trim_o     = q.trim;
    assign locked_o   = q.locked;
    assign error_o    = q.error;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |=> !meas_req_o); // R4
    AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && !meas_done_i) |=> $stable(trim_o)); // R4
    AST_FINE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && meas_done_i) |=>
        ((trim_o[FINE_W-1:0] - $past(trim_o[FINE_W-1:0])) inside {FINE_W'(0), FINE_W'(1), {FINE_W{1'b1}}})); // R5
    AST_NO_REQ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o || error_o) |-> !meas_req_o); // R6
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.iter <= ITER_W'(MAX_ITER)); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && error_o)); // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !run_i) |=> locked_o); // R9
endmodule

// File: tb/dfll_trim_ctrl_bench.sv
module dfll_trim_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [23:0] target_hz_i = '0;
    logic        meas_req_o;
    logic        meas_done_i = 1'b0;
    logic [15:0] meas_count_i = '0;
    logic [10:0] trim_o;
    logic        locked_o, error_o;

    int errors = 0;
    int checks = 0;
    int nreq = 0;
    int osc_off = 0;
    int osc_target = 0;

    always #2.5 clk = ~clk;

    dfll_trim_ctrl u_dfll_trim_ctrl (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .target_hz_i(target_hz_i),
        .meas_req_o(meas_req_o), .meas_done_i(meas_done_i), .meas_count_i(meas_count_i),
        .trim_o(trim_o), .locked_o(locked_o), .error_o(error_o)
    );

    function automatic int nb_of(int f);
        return (f < 650000) ? 20 : 1;
    endfunction
    function automatic int expect_of(int f);
        longint p = longint'(nb_of(f) + 1) * longint'(f);
        return int'(p >>> 15);
    endfunction
    function automatic int rng_of(int f);
        return (f >= 1000000) ? 1 : 0;
    endfunction
    function automatic int coarse_of(int f);
        int base = rng_of(f) ? 1000000 : 100000;
        int step = rng_of(f) ? 562500 : 56250;
        int c;
        if (f < base) return 0;
        c = (f - base) / step;
        return (c > 15) ? 15 : c;
    endfunction
    function automatic int init_trim(int f);
        return (rng_of(f) << 10) | (coarse_of(f) << 6) | 32;
    endfunction
    function automatic int fstep_of(int f);
        return rng_of(f) ? 15000 : 1500;
    endfunction
    // oscillator model: nominal curve plus a process offset
    function automatic int osc_count(int trim, int off, int f);
        int r = (trim >> 10) & 1;
        int co = (trim >> 6) & 15;
        int fi = trim & 63;
        longint fr, c;
        fr = r ? (64'd1000000 + co * 562500 + (fi - 32) * 15000)
               : (64'd100000 + co * 56250 + (fi - 32) * 1500);
        fr = fr + off;
        if (fr < 0) fr = 0;
        c = (longint'(nb_of(f) + 1) * fr) >>> 15;
        if (c > 65535) c = 65535;
        return int'(c);
    endfunction
    task automatic ref_run(input int f, input int off, output int trim, output int lk,
                           output int er, output int n);
        int lo = expect_of(f) * 98 / 100;
        int hi = expect_of(f) * 102 / 100;
        int fine = 32;
        int c;
        lk = 0; er = 0; n = 0;
        trim = init_trim(f);
        for (int i = 1; i <= 64; i++) begin
            c = osc_count(trim, off, f);
            n = i;
            if (c >= lo && c <= hi) begin lk = 1; return; end
            if (i == 64) begin er = 1; return; end
            if (c > hi && fine > 0) fine--;
            else if (c < lo && fine < 63) fine++;
            trim = (trim & ~63) | fine;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // measurement responder
    initial begin
        forever begin
            @(negedge clk);
            meas_done_i = 1'b0;
            if (meas_req_o) begin
                nreq++;
                repeat (1 + ($urandom % 4)) @(negedge clk);
                meas_count_i = 16'(osc_count(int'(trim_o), osc_off, osc_target));
                meas_done_i = 1'b1;
            end
        end
    end

    task automatic do_run(input int f, input int off, input bit disturb);
        int et, elk, eer, en;
        ref_run(f, off, et, elk, eer, en);
        osc_off = off;
        osc_target = f;
        nreq = 0;
        run_i = 1'b1;
        target_hz_i = 24'(f);
        @(negedge clk);
        run_i = 1'b0;
        check("R2 init trim", int'(trim_o), init_trim(f));
        check("R2 flags cleared", int'({locked_o, error_o}), 0);
        if (disturb) begin
            while (nreq < 2 && !(locked_o || error_o)) @(negedge clk);
            run_i = 1'b1;   // R8: must be dropped
            target_hz_i = 24'(f ^ 24'h3FFFF);
            @(negedge clk);
            run_i = 1'b0;
        end
        while (!(locked_o || error_o)) @(negedge clk);
        check(disturb ? "R8 final trim" : "R5 final trim", int'(trim_o), et);
        check("R3 R6 locked", int'(locked_o), elk);
        check("R7 error", int'(error_o), eer);
        check("R4 requests", nreq, en);
        repeat (4) @(negedge clk);
        check("R9 flags hold", int'({locked_o, error_o}), (elk << 1) | eer);
        check("R6 no further requests", nreq, en);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset trim", int'(trim_o), 32'h020);
        check("R1 reset flags", int'({locked_o, error_o, meas_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        do_run(649999, 0, 1'b0);
        do_run(650000, 0, 1'b0);
        do_run(999999, 3000, 1'b0);
        do_run(1000000, -20000, 1'b0);
        do_run(50000, 40000, 1'b0);
        do_run(10000000, 0, 1'b0);
        do_run(300000, 1500 * 200, 1'b0);     // R5 saturate at 0, R7
        check("R5 fine floor", int'(trim_o) & 63, 0);
        do_run(5000000, -15000 * 200, 1'b0);  // R5 saturate at 63, R7
        check("R5 fine ceiling", int'(trim_o) & 63, 63);
        do_run(420000, 6000, 1'b1);
        do_run(2500000, -90000, 1'b1);
        // random targets and offsets
        for (int i = 0; i < 24; i++) begin
            int f = 100000 + int'($urandom_range(9800000));
            int k = int'($urandom_range(30)) - 15;
            do_run(f, k * fstep_of(f), 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule